// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the addresses of a short burst into a synchronous memory. A start address and an access type come in on a load cycle. After that, each continue cycle moves the low two address bits to the next beat. The whole burst is four beats long. It then wraps back to the start. The upper address bits stay where the load put them.

An ordering input is sampled on the load cycle and selects one of two beat orders. In linear order the low bits count upward modulo four from the start value. In interleaved order the low bits are the start value XOR the beat number.

The read/write type is frozen on the load cycle. On a continue cycle the block ignores the write-enable input and the start address input. A stall input holds every stored value for as long as it is high. The memory array and the data path are not part of this block.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low, `cur_addr` is 0 and `burst_wr` is 0.
- R2: A load happens on a rising edge where `clk_hold` is 0 and `advance` is 0. After that edge, `cur_addr` equals `start_addr` and `burst_wr` equals `wr_req`, both as they were at the edge.
- R3: Linear order is selected when `interleave` is 0 on the load edge. Let n be the number of continue edges since the load (`clk_hold` 0, `advance` 1). The low two bits of `cur_addr` are then (s + n) mod 4, where s is the low two bits of the start address. The fourth continue edge returns them to s.
- R4: Interleaved order is selected when `interleave` is 1 on the load edge. The low two bits of `cur_addr` are then s XOR (n mod 4).
- R5: Bits above the low two of `cur_addr` do not change on a continue edge.
- R6: On a continue edge, `wr_req` and `start_addr` have no effect. `burst_wr` keeps the value captured on the load edge, and the beat sequence is unchanged.
- R7: On an edge where `clk_hold` is 1, `cur_addr` and `burst_wr` do not change. This holds for both a load request and a continue request. The burst then resumes from the beat where it stopped.
- R8: The beat order is fixed by `interleave` on the load edge. Changing `interleave` during continue edges does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_hold | input | 1 | 1 = stall: no state changes on this edge |
| advance | input | 1 | 0 = load start address, 1 = continue to next beat |
| interleave | input | 1 | Beat order sampled on load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W (16) | Start address for a load |
| wr_req | input | 1 | Access type for a load: 1 write, 0 read |
| cur_addr | output | ADDR_W (16) | Address of the current beat |
| burst_wr | output | 1 | Access type frozen at the load |

## Verification
The bench drives each order far enough to pass the wrap on the fourth beat. A design that saturates, or that lets the carry of a linear count spill into bit 2, shows a wrong address on that beat.

Continue cycles carry a changed write-enable and a changed start address. A design that samples either of them mid-burst flips `burst_wr` or jumps to the new address.

Stalled edges carry both a load request and a continue request. A design that gates only part of the state either skips a beat or reloads.

Flipping the order input mid-burst exposes a design that reads the order input live instead of latching it at the load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

endpackage

// File: rtl/burst_seq_cmd.sv
module burst_seq_cmd
    import burst_seq_pkg::*;
(
    input  logic clk_hold,
    input  logic advance,
    output cmd_e cmd
);
    // A stalled edge decodes to idle whatever advance says.
    always_comb begin
        if (clk_hold)     cmd = CMD_IDLE;
        else if (advance) cmd = CMD_STEP;
        else              cmd = CMD_LOAD;
    end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  order_e            order,
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] lane
);
    logic [BEAT_W-1:0] lin_lane;
    logic [BEAT_W-1:0] ilv_lane;

    // The sum is truncated to BEAT_W bits, so the count wraps.
    assign lin_lane = base + beat;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
            assign ilv_lane[gi] = base[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        case (order)
            ORD_INTERLEAVE: lane = ilv_lane;
            default:        lane = lin_lane;
        endcase
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_hold,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_wr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        order_e            order;
        logic              wr;
    } state_t;

    state_t            st_d, st_q;
    cmd_e              cmd;
    logic [BEAT_W-1:0] beat_inc;
    logic [BEAT_W-1:0] lane_nxt;
    logic [UPPER_W-1:0] upper_q;
    order_e            ord_q;

    burst_seq_cmd i_cmd (
        .clk_hold (clk_hold),
        .advance  (advance),
        .cmd      (cmd)
    );

    assign beat_inc = st_q.beat + BEAT_ONE;
    assign upper_q  = st_q.addr[ADDR_W-1:BEAT_W];
    assign ord_q    = st_q.order;

    burst_seq_order #(.BEAT_W(BEAT_W)) i_order (
        .order (st_q.order),
        .base  (st_q.base),
        .beat  (beat_inc),
        .lane  (lane_nxt)
    );

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: begin
                st_d.addr  = start_addr;
                st_d.base  = start_addr[BEAT_W-1:0];
                st_d.beat  = '0;
                st_d.order = order_e'(interleave);
                st_d.wr    = wr_req;
            end
            CMD_STEP: begin
                st_d.beat = beat_inc;
                st_d.addr = {upper_q, lane_nxt};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.addr;
    assign burst_wr = st_q.wr;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_hold,
    input logic              advance,
    input logic [ADDR_W-1:0] start_addr,
    input logic              wr_req,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              burst_wr,
    input logic              ord_q
);
    logic [BEAT_W-1:0] lin_next;
    assign lin_next = cur_addr[BEAT_W-1:0] + {{(BEAT_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (cur_addr == '0 && burst_wr == 1'b0); // R1
        end
    end

    AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && !advance) |=> (cur_addr == $past(start_addr) && burst_wr == $past(wr_req))); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && advance && !ord_q) |=> (cur_addr[BEAT_W-1:0] == $past(lin_next))); // R3

    AST_ILV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && advance && ord_q) |=> (cur_addr[BEAT_W-1:0] != $past(cur_addr[BEAT_W-1:0]))); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && advance) |=> $stable(cur_addr[ADDR_W-1:BEAT_W])); // R5

    AST_TYPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && advance) |=> $stable(burst_wr)); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |=> ($stable(cur_addr) && $stable(burst_wr))); // R7

    AST_ORDER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_hold || advance) |=> $stable(ord_q)); // R8
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_hold   (clk_hold),
    .advance    (advance),
    .start_addr (start_addr),
    .wr_req     (wr_req),
    .cur_addr   (cur_addr),
    .burst_wr   (burst_wr),
    .ord_q      (ord_q)
);

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_hold = 1'b0;
    logic        advance = 1'b0;
    logic        interleave = 1'b0;
    logic [15:0] start_addr = '0;
    logic        wr_req = 1'b0;
    logic [15:0] cur_addr;
    logic        burst_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_seq i_burst_seq (
        .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .advance(advance),
        .interleave(interleave), .start_addr(start_addr), .wr_req(wr_req),
        .cur_addr(cur_addr), .burst_wr(burst_wr)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at negedge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic h, input logic a, input logic m,
                        input logic [15:0] sa, input logic w);
        @(negedge clk);
        clk_hold = h; advance = a; interleave = m; start_addr = sa; wr_req = w;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] s, input int n, input logic ilv);
        logic [1:0] nb;
        logic [1:0] lo;
        nb = 2'(n);
        lo = ilv ? (s[1:0] ^ nb) : (s[1:0] + nb);
        return {s[15:2], lo};
    endfunction

    task automatic t_reset();
        #1;
        chk("R1 addr", cur_addr, 16'h0000);
        chk("R1 wr", {15'd0, burst_wr}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_burst(input logic [15:0] s, input logic w, input logic ilv, input string req);
        step(1'b0, 1'b0, ilv, s, w);
        chk("R2 load addr", cur_addr, s);
        chk("R2 load wr", {15'd0, burst_wr}, {15'd0, w});
        for (int n = 1; n <= 5; n++) begin
            // R6: junk start address and opposite write-enable on continue
            step(1'b0, 1'b1, ilv, ~s, ~w);
            chk(req, cur_addr, exp_addr(s, n, ilv));
            chk("R5 upper", {2'b00, cur_addr[15:2]}, {2'b00, s[15:2]});
            chk("R6 wr", {15'd0, burst_wr}, {15'd0, w});
        end
    endtask

    task automatic t_hold();
        logic [15:0] s = 16'h1233;
        step(1'b0, 1'b0, 1'b0, s, 1'b1);
        step(1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
        chk("R3 pre-hold", cur_addr, exp_addr(s, 1, 1'b0));
        step(1'b1, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R7 hold on continue", cur_addr, exp_addr(s, 1, 1'b0));
        step(1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b0);
        chk("R7 hold on load", cur_addr, exp_addr(s, 1, 1'b0));
        chk("R7 hold wr", {15'd0, burst_wr}, 16'h0001);
        step(1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R7 resume", cur_addr, exp_addr(s, 2, 1'b0));
    endtask

    task automatic t_mode_flip();
        logic [15:0] s = 16'h7781;
        step(1'b0, 1'b0, 1'b0, s, 1'b0);
        for (int n = 1; n <= 3; n++) begin
            step(1'b0, 1'b1, 1'b1, 16'h0, 1'b1);
            chk("R8 order latched", cur_addr, exp_addr(s, n, 1'b0));
        end
        s = 16'h4402;
        step(1'b0, 1'b0, 1'b1, s, 1'b0);
        for (int n = 1; n <= 3; n++) begin
            step(1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
            chk("R8 order latched ilv", cur_addr, exp_addr(s, n, 1'b1));
        end
    endtask

    initial begin
        t_reset();
        t_burst(16'hA5B2, 1'b1, 1'b0, "R3 linear");
        t_burst(16'h3C43, 1'b0, 1'b0, "R3 linear wrap");
        t_burst(16'h3C41, 1'b0, 1'b1, "R4 interleave");
        t_burst(16'hF00E, 1'b1, 1'b1, "R4 interleave wrap");
        t_hold();
        t_mode_flip();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule